// File: doc/BRIEF.md
# Flash Program Sequencer

This block is the programming front end of a flash controller. It holds a small behavioural model of a main array, stored as 16-bit half words, and of an option area of eight 16-bit option pairs. Software must open the control path with a two-key sequence before it can set any program or erase bit. It opens the option area with a second two-key sequence, which is only accepted while the control path is open. It then sets a program-enable bit and issues a half-word or word bus write to the target location. The block holds busy for a fixed number of cycles and then reports the result through an end flag, an error flag and an interrupt line.

A program request is checked against the current contents of the location. A half word that is not in the erased state of all ones may only be overwritten with zero. Any other value raises the error flag and leaves the memory unchanged. In the option area only the low byte of each pair is taken from the write data, and the high byte is always stored as its bitwise complement. The option values that the rest of the chip sees are latched from the option area only after a system reset. A page-erase command, an option-area erase command and a combinational read port complete the block.

Two resets are used. `por_n` also returns both arrays to the erased state. `rst_n` clears only the control and status state and reloads the option values, so the stored contents survive it.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the control path is locked. It opens only when `key_data` is written with KEY_A and then, on the next key write, with KEY_B. Any other second value returns it to locked. While it is locked, or while busy is high, control writes are ignored. A control write with bit 6 set locks the path again and clears both program-enable bits.
- R2: The option write enable (`opt_wen`) rises only when the option keys OKEY_A and then OKEY_B are written while the control path is open. Locking the control path drops it. The option program bit (control bit 1) is stored as 1 only while `opt_wen` is high.
- R3: With main program enable set (control bit 0), a bus write is accepted. When `bus_word`=0 it writes `bus_wdata[15:0]` to half word `bus_hw_addr`. When `bus_word`=1 it writes the low half to the even half word `bus_hw_addr` with bit 0 cleared, and the high half to the odd half word above it. The erased value is 16'hFFFF.
- R4: Busy rises on the clock edge that accepts a request. It stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R5: When an operation completes without error, the end flag is set. `irq` is high exactly when the end flag and the interrupt enable (control bit 5) are both set.
- R6: If any target half word is not 16'hFFFF and the value to be written to it is non-zero, the operation sets the program-error flag. It then writes nothing and leaves the end flag unchanged.
- R7: In option programming (control bit 1), the pair index is `bus_hw_addr[2:0]`. A half-word write stores {~d[7:0], d[7:0]} into that pair. A word write does the same for the even pair using d[7:0] and for the next pair using d[23:16]. The error rule of R6 applies with the pair's low byte as the value.
- R8: `opt_active` byte i holds the low byte of option pair i. It is reloaded only in the first cycle after reset, and all bytes read 8'hFF while reset is applied.
- R9: A bus write while busy, while locked, or with no program enable starts no operation. It changes no flag and leaves the memory unchanged.
- R10: Writing 1 to `stat_wdata[0]` clears the end flag, and writing 1 to `stat_wdata[1]` clears the error flag. A flag being set in the same cycle wins.
- R11: A control write with the start bit (4) and page erase (bit 2) sets all half words of page `ctl_wdata[9:7]` to 16'hFFFF. Start with option erase (bit 3) while `opt_wen` is high sets all option pairs to 16'hFFFF. Page erase has priority.
- R12: `rd_data` shows, combinationally, half word `rd_hw_addr` of the main array when `rd_opt`=0, or option pair `rd_hw_addr[2:0]` when `rd_opt`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also erases both arrays |
| rst_n | input | 1 | System reset, active low; keeps array contents |
| key_wr | input | 1 | Control key write strobe |
| key_data | input | 32 | Control key value |
| okey_wr | input | 1 | Option key write strobe |
| okey_data | input | 32 | Option key value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 10 | Control bits: 0 program, 1 option program, 2 page erase, 3 option erase, 4 start, 5 interrupt enable, 6 lock, 9:7 page |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Write-one-to-clear: 0 end flag, 1 error flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_word | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| bus_hw_addr | input | 7 | Half-word address of the write |
| bus_wdata | input | 32 | Write data |
| rd_opt | input | 1 | Read port selects the option area |
| rd_hw_addr | input | 7 | Read address (half word, or pair in bits 2:0) |
| rd_data | output | 16 | Read data |
| busy | output | 1 | Operation in progress |
| end_flag | output | 1 | Successful completion flag |
| prog_err | output | 1 | Program error flag |
| irq | output | 1 | End interrupt |
| ctl_locked | output | 1 | Control path locked |
| opt_wen | output | 1 | Option area write enable |
| opt_active | output | 64 | Option values in effect, byte i from pair i |

## Verification
Programming is tried with half-word writes to erased cells, word writes that split across an even/odd pair, and overwrites of programmed cells with a non-zero value and with zero. Together these separate the erased-check, the zero exemption and the half ordering. Option writes are tried with an odd pair, an even-aligned word and an overwrite. This shows that the high byte comes from the complement and not from the data, and that a failed write leaves the pair intact. Requests made while locked, while busy, or after a wrong second key show that the lock and busy gating block every side effect. A system reset between option programming and readback shows that `opt_active` only changes at reset while the arrays keep their contents.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_MAIN_PROG  = 2'd0,
    OP_OPT_PROG   = 2'd1,
    OP_PAGE_ERASE = 2'd2,
    OP_OPT_ERASE  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  // control word bit positions
  localparam int CTL_PG       = 0;
  localparam int CTL_OPG      = 1;
  localparam int CTL_PER      = 2;
  localparam int CTL_OER      = 3;
  localparam int CTL_START    = 4;
  localparam int CTL_ENDIE    = 5;
  localparam int CTL_LOCK     = 6;
  localparam int CTL_PAGE_LSB = 7;

  // status word bit positions
  localparam int STAT_END = 0;
  localparam int STAT_ERR = 1;

  localparam int OPT_PAIRS = 8;
  localparam int OPT_W     = 3;

  localparam logic [15:0] ERASED_HW = 16'hFFFF;

  // stored image of an option pair: complement above, value below
  function automatic logic [15:0] opt_image(input logic [7:0] lo);
    return {~lo, lo};
  endfunction

  // a write to a non-erased half word is only legal when it writes zero
  function automatic logic hw_conflict(input logic [15:0] cur, input logic [15:0] nxt);
    return (cur != ERASED_HW) && (nxt != 16'h0000);
  endfunction

endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
  import flash_seq_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'h0,
  parameter logic [31:0] KEY_B = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        allow,
  input  logic        relock,
  input  logic        wr,
  input  logic [31:0] data,
  output logic        open
);

  key_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_LOCKED;
    end else if (relock || !allow) begin
      st_q <= KS_LOCKED;
    end else if (wr) begin
      case (st_q)
        KS_LOCKED: st_q <= (data == KEY_A) ? KS_HALF : KS_LOCKED;
        KS_HALF:   st_q <= (data == KEY_B) ? KS_OPEN : KS_LOCKED;
        default:   st_q <= st_q;
      endcase
    end
  end

  assign open = (st_q == KS_OPEN);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic is_erase,
  output logic busy,
  output logic done
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc) begin
      busy_q <= 1'b1;
      cnt_q  <= is_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/flash_array_store.sv
module flash_array_store
  import flash_seq_pkg::*;
#(
  parameter int HW_DEPTH = 128,
  parameter int PAGE_HW  = 16
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     acc,
  input  op_kind_e                 acc_kind,
  input  logic                     acc_word,
  input  logic [$clog2(HW_DEPTH)-1:0] acc_hw_idx,
  input  logic [31:0]              acc_data,
  input  logic [$clog2(HW_DEPTH/PAGE_HW)-1:0] acc_page,
  input  logic                     done,
  output logic                     done_err,
  input  logic                     rd_opt,
  input  logic [$clog2(HW_DEPTH)-1:0] rd_hw_idx,
  output logic [15:0]              rd_data,
  output logic [8*OPT_PAIRS-1:0]   opt_lo_all
);

  localparam int HW_W  = $clog2(HW_DEPTH);
  localparam int PG_W  = $clog2(HW_DEPTH / PAGE_HW);
  localparam int PG_SH = $clog2(PAGE_HW);

  logic [15:0] main_q [HW_DEPTH];
  logic [15:0] opt_q  [OPT_PAIRS];

  op_kind_e          l_kind;
  logic              l_word;
  logic [HW_W-1:0]   l_hw;
  logic [31:0]       l_data;
  logic [PG_W-1:0]   l_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_kind <= OP_MAIN_PROG;
      l_word <= 1'b0;
      l_hw   <= '0;
      l_data <= '0;
      l_page <= '0;
    end else if (acc) begin
      l_kind <= acc_kind;
      l_word <= acc_word;
      l_hw   <= acc_hw_idx;
      l_data <= acc_data;
      l_page <= acc_page;
    end
  end

  // target locations of the latched operation
  logic [HW_W-1:0]  hw0, hw1;
  logic [OPT_W-1:0] p0, p1;
  logic [15:0]      d0, d1;
  logic [7:0]       lo0, lo1;

  always_comb begin
    hw0 = l_word ? {l_hw[HW_W-1:1], 1'b0} : l_hw;
    hw1 = hw0 | HW_W'(1);
    p0  = l_word ? {l_hw[OPT_W-1:1], 1'b0} : l_hw[OPT_W-1:0];
    p1  = p0 | OPT_W'(1);
    d0  = l_data[15:0];
    d1  = l_data[31:16];
    lo0 = l_data[7:0];
    lo1 = l_data[23:16];
  end

  logic op_err;

  always_comb begin
    case (l_kind)
      OP_MAIN_PROG: op_err = hw_conflict(main_q[hw0], d0)
                           || (l_word && hw_conflict(main_q[hw1], d1));
      OP_OPT_PROG:  op_err = hw_conflict(opt_q[p0], {8'h00, lo0})
                           || (l_word && hw_conflict(opt_q[p1], {8'h00, lo1}));
      default:      op_err = 1'b0;
    endcase
  end

  assign done_err = done && op_err;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < HW_DEPTH; i++)  main_q[i] <= ERASED_HW;
      for (int j = 0; j < OPT_PAIRS; j++) opt_q[j]  <= ERASED_HW;
    end else if (done) begin
      case (l_kind)
        OP_MAIN_PROG: if (!op_err) begin
          main_q[hw0] <= d0;
          if (l_word) main_q[hw1] <= d1;
        end
        OP_OPT_PROG: if (!op_err) begin
          opt_q[p0] <= opt_image(lo0);
          if (l_word) opt_q[p1] <= opt_image(lo1);
        end
        OP_PAGE_ERASE: begin
          for (int i = 0; i < PAGE_HW; i++) main_q[{l_page, PG_SH'(i)}] <= ERASED_HW;
        end
        default: begin
          for (int j = 0; j < OPT_PAIRS; j++) opt_q[j] <= ERASED_HW;
        end
      endcase
    end
  end

  generate
    for (genvar g = 0; g < OPT_PAIRS; g++) begin : g_opt_lo
      assign opt_lo_all[8*g +: 8] = opt_q[g][7:0];
    end
  endgenerate

  assign rd_data = rd_opt ? opt_q[rd_hw_idx[OPT_W-1:0]] : main_q[rd_hw_idx];

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int          HW_DEPTH  = 128,
  parameter int          PAGE_HW   = 16,
  parameter int          PROG_CYC  = 6,
  parameter int          ERASE_CYC = 20,
  parameter logic [31:0] KEY_A     = 32'hA5C3_1E70,
  parameter logic [31:0] KEY_B     = 32'h5B0F_E2D4,
  parameter logic [31:0] OKEY_A    = 32'h1357_9BDF,
  parameter logic [31:0] OKEY_B    = 32'h2468_ACE0,
  localparam int         HW_W      = $clog2(HW_DEPTH),
  localparam int         PG_W      = $clog2(HW_DEPTH / PAGE_HW),
  localparam int         CTL_W     = CTL_PAGE_LSB + PG_W
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   key_wr,
  input  logic [31:0]            key_data,
  input  logic                   okey_wr,
  input  logic [31:0]            okey_data,
  input  logic                   ctl_wr,
  input  logic [CTL_W-1:0]       ctl_wdata,
  input  logic                   stat_wr,
  input  logic [1:0]             stat_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_word,
  input  logic [HW_W-1:0]        bus_hw_addr,
  input  logic [31:0]            bus_wdata,
  input  logic                   rd_opt,
  input  logic [HW_W-1:0]        rd_hw_addr,
  output logic [15:0]            rd_data,
  output logic                   busy,
  output logic                   end_flag,
  output logic                   prog_err,
  output logic                   irq,
  output logic                   ctl_locked,
  output logic                   opt_wen,
  output logic [8*OPT_PAIRS-1:0] opt_active
);

  logic rst_all_n;
  assign rst_all_n = por_n & rst_n;

  // named internal events
  logic ctrl_open, opt_open;
  logic ctl_ok, relock, erase_acc, prog_acc, acc, done, done_err;
  logic use_opt;
  op_kind_e acc_kind;

  logic pg_q, opg_q, endie_q, endf_q, err_q;
  logic reload_q;
  logic [8*OPT_PAIRS-1:0] active_q, opt_lo_all;

  assign ctl_ok    = ctl_wr && ctrl_open && !busy;
  assign relock    = ctl_ok && ctl_wdata[CTL_LOCK];
  assign erase_acc = ctl_ok && !ctl_wdata[CTL_LOCK] && ctl_wdata[CTL_START]
                     && (ctl_wdata[CTL_PER] || (ctl_wdata[CTL_OER] && opt_open));
  assign use_opt   = opg_q && opt_open;
  assign prog_acc  = bus_wr && !ctl_wr && ctrl_open && !busy && (pg_q || use_opt);
  assign acc       = prog_acc || erase_acc;

  always_comb begin
    if (erase_acc) acc_kind = ctl_wdata[CTL_PER] ? OP_PAGE_ERASE : OP_OPT_ERASE;
    else           acc_kind = use_opt ? OP_OPT_PROG : OP_MAIN_PROG;
  end

  flash_key_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_ctl_key (
    .clk(clk), .rst_n(rst_all_n), .allow(1'b1), .relock(relock),
    .wr(key_wr), .data(key_data), .open(ctrl_open)
  );

  flash_key_unlock #(.KEY_A(OKEY_A), .KEY_B(OKEY_B)) u_opt_key (
    .clk(clk), .rst_n(rst_all_n), .allow(ctrl_open), .relock(relock),
    .wr(okey_wr), .data(okey_data), .open(opt_open)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_all_n), .acc(acc), .is_erase(erase_acc),
    .busy(busy), .done(done)
  );

  flash_array_store #(.HW_DEPTH(HW_DEPTH), .PAGE_HW(PAGE_HW)) u_store (
    .clk(clk), .por_n(por_n), .rst_n(rst_all_n),
    .acc(acc), .acc_kind(acc_kind), .acc_word(bus_word),
    .acc_hw_idx(bus_hw_addr), .acc_data(bus_wdata),
    .acc_page(ctl_wdata[CTL_PAGE_LSB +: PG_W]),
    .done(done), .done_err(done_err),
    .rd_opt(rd_opt), .rd_hw_idx(rd_hw_addr), .rd_data(rd_data),
    .opt_lo_all(opt_lo_all)
  );

  // control bits
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      pg_q    <= 1'b0;
      opg_q   <= 1'b0;
      endie_q <= 1'b0;
    end else if (ctl_ok) begin
      if (ctl_wdata[CTL_LOCK]) begin
        pg_q  <= 1'b0;
        opg_q <= 1'b0;
      end else begin
        pg_q    <= ctl_wdata[CTL_PG];
        opg_q   <= ctl_wdata[CTL_OPG] && opt_open;
        endie_q <= ctl_wdata[CTL_ENDIE];
      end
    end
  end

  // status flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      endf_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      endf_q <= (done && !done_err) || (endf_q && !(stat_wr && stat_wdata[STAT_END]));
      err_q  <= done_err || (err_q && !(stat_wr && stat_wdata[STAT_ERR]));
    end
  end

  // option values take effect once per reset
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      active_q <= '1;
      reload_q <= 1'b1;
    end else if (reload_q) begin
      active_q <= opt_lo_all;
      reload_q <= 1'b0;
    end
  end

  assign end_flag   = endf_q;
  assign prog_err   = err_q;
  assign irq        = endf_q && endie_q;
  assign ctl_locked = !ctrl_open;
  assign opt_wen    = opt_open;
  assign opt_active = active_q;

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc,
  input logic       done,
  input logic       done_err,
  input logic       busy,
  input logic       end_flag,
  input logic       prog_err,
  input logic       irq,
  input logic       ctl_locked,
  input logic       opt_wen,
  input logic       stat_wr,
  input logic [1:0] stat_wdata
);

  assert_busy_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !busy);

  assert_end_on_success_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |=> end_flag);

  assert_irq_needs_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> end_flag);

  assert_err_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> prog_err);

  assert_err_keeps_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_err && !end_flag) |=> !end_flag);

  assert_end_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[0] && !done) |=> !end_flag);

  assert_start_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ctl_locked));

  assert_optwen_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wen |-> !ctl_locked);

endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_all_n), .acc(acc), .done(done), .done_err(done_err),
  .busy(busy), .end_flag(end_flag), .prog_err(prog_err), .irq(irq),
  .ctl_locked(ctl_locked), .opt_wen(opt_wen),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 20;
  localparam logic [31:0] KA  = 32'hA5C3_1E70;
  localparam logic [31:0] KB  = 32'h5B0F_E2D4;
  localparam logic [31:0] OKA = 32'h1357_9BDF;
  localparam logic [31:0] OKB = 32'h2468_ACE0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, rst_n, key_wr, okey_wr, ctl_wr, stat_wr, bus_wr, bus_word, rd_opt;
  logic [31:0] key_data, okey_data, bus_wdata;
  logic [9:0]  ctl_wdata;
  logic [1:0]  stat_wdata;
  logic [6:0]  bus_hw_addr, rd_hw_addr;
  logic [15:0] rd_data;
  logic busy, end_flag, prog_err, irq, ctl_locked, opt_wen;
  logic [63:0] opt_active;

  flash_prog_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .key_wr(key_wr), .key_data(key_data), .okey_wr(okey_wr), .okey_data(okey_data),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_hw_addr(bus_hw_addr), .bus_wdata(bus_wdata),
    .rd_opt(rd_opt), .rd_hw_addr(rd_hw_addr), .rd_data(rd_data),
    .busy(busy), .end_flag(end_flag), .prog_err(prog_err), .irq(irq),
    .ctl_locked(ctl_locked), .opt_wen(opt_wen), .opt_active(opt_active)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_cst, m_ost, m_cnt;
  bit          m_pg, m_opg, m_ie, m_busy, m_endf, m_err, m_reload;
  logic [15:0] m_main [128];
  logic [15:0] m_opt  [8];
  logic [63:0] m_active;
  int          o_kind, o_hw, o_page;
  bit          o_word;
  logic [31:0] o_data;

  function automatic bit bad(input logic [15:0] cur, input logic [15:0] nv);
    return cur != 16'hFFFF && nv != 16'h0;
  endfunction

  always @(posedge clk) begin
    bit dn, e, cok, rl, er, uo, pr;
    int a, p;
    if (!por_n || !rst_n) begin
      if (!por_n) begin
        for (int i = 0; i < 128; i++) m_main[i] = 16'hFFFF;
        for (int i = 0; i < 8; i++)   m_opt[i]  = 16'hFFFF;
      end
      m_cst = 0; m_ost = 0; m_cnt = 0;
      m_pg = 0; m_opg = 0; m_ie = 0; m_busy = 0; m_endf = 0; m_err = 0;
      m_reload = 1; m_active = '1;
      o_kind = 0; o_hw = 0; o_page = 0; o_word = 0; o_data = 0;
    end else begin
      dn = m_busy && m_cnt == 0;
      e  = 0;
      if (dn) begin
        if (o_kind == 0) begin
          a = o_word ? (o_hw & ~1) : o_hw;
          e = bad(m_main[a], o_data[15:0]) || (o_word && bad(m_main[a+1], o_data[31:16]));
          if (!e) begin
            m_main[a] = o_data[15:0];
            if (o_word) m_main[a+1] = o_data[31:16];
          end
        end else if (o_kind == 1) begin
          p = o_word ? (o_hw & 6) : (o_hw & 7);
          e = bad(m_opt[p], {8'h0, o_data[7:0]}) || (o_word && bad(m_opt[p+1], {8'h0, o_data[23:16]}));
          if (!e) begin
            m_opt[p] = {~o_data[7:0], o_data[7:0]};
            if (o_word) m_opt[p+1] = {~o_data[23:16], o_data[23:16]};
          end
        end else if (o_kind == 2) begin
          for (int i = 0; i < 16; i++) m_main[o_page*16 + i] = 16'hFFFF;
        end else begin
          for (int i = 0; i < 8; i++) m_opt[i] = 16'hFFFF;
        end
      end
      m_endf = (dn && !e) || (m_endf && !(stat_wr && stat_wdata[0]));
      m_err  = (dn && e)  || (m_err  && !(stat_wr && stat_wdata[1]));

      cok = ctl_wr && m_cst == 2 && !m_busy;
      rl  = cok && ctl_wdata[6];
      er  = cok && !ctl_wdata[6] && ctl_wdata[4] && (ctl_wdata[2] || (ctl_wdata[3] && m_ost == 2));
      uo  = m_opg && m_ost == 2;
      pr  = bus_wr && !ctl_wr && m_cst == 2 && !m_busy && (m_pg || uo);

      if (pr) begin
        o_kind = uo ? 1 : 0; o_word = bus_word; o_hw = bus_hw_addr; o_data = bus_wdata;
      end
      if (er) begin
        o_kind = ctl_wdata[2] ? 2 : 3; o_page = ctl_wdata[9:7];
      end

      if (pr || er) begin
        m_busy = 1; m_cnt = er ? ERASE_CYC - 1 : PROG_CYC - 1;
      end else if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end

      if (cok) begin
        if (rl) begin m_pg = 0; m_opg = 0; end
        else begin
          m_pg = ctl_wdata[0]; m_opg = ctl_wdata[1] && m_ost == 2; m_ie = ctl_wdata[5];
        end
      end

      if (rl || m_cst != 2) m_ost = 0;
      else if (okey_wr) begin
        if (m_ost == 0) m_ost = (okey_data == OKA) ? 1 : 0;
        else if (m_ost == 1) m_ost = (okey_data == OKB) ? 2 : 0;
      end
      if (rl) m_cst = 0;
      else if (key_wr) begin
        if (m_cst == 0) m_cst = (key_data == KA) ? 1 : 0;
        else if (m_cst == 1) m_cst = (key_data == KB) ? 2 : 0;
      end

      if (m_reload) begin
        for (int i = 0; i < 8; i++) m_active[8*i +: 8] = m_opt[i][7:0];
        m_reload = 0;
      end
    end
  end

  // every-clock comparison of registered outputs
  always @(negedge clk) begin
    check(busy, m_busy, "R4 busy");
    check(end_flag, m_endf, "R5 end_flag");
    check(prog_err, m_err, "R6 prog_err");
    check(irq, m_endf && m_ie, "R5 irq");
    check(ctl_locked, m_cst != 2, "R1 ctl_locked");
    check(opt_wen, m_ost == 2, "R2 opt_wen");
    check(opt_active, m_active, "R8 opt_active");
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic key_w(input logic [31:0] d);
    key_wr = 1; key_data = d; @(negedge clk); key_wr = 0;
  endtask
  task automatic okey_w(input logic [31:0] d);
    okey_wr = 1; okey_data = d; @(negedge clk); okey_wr = 0;
  endtask
  task automatic ctl_w(input logic [9:0] d);
    ctl_wr = 1; ctl_wdata = d; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic stat_w(input logic [1:0] d);
    stat_wr = 1; stat_wdata = d; @(negedge clk); stat_wr = 0;
  endtask
  task automatic bus_w(input int hw, input bit word, input logic [31:0] d);
    bus_wr = 1; bus_word = word; bus_hw_addr = 7'(hw); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
  endtask
  task automatic rd(input bit opt, input int a, input logic [15:0] exp, input string tag);
    rd_opt = opt; rd_hw_addr = 7'(a); #1;
    check(rd_data, exp, tag);
  endtask

  initial begin
    int n;
    por_n = 0; rst_n = 0; key_wr = 0; okey_wr = 0; ctl_wr = 0; stat_wr = 0; bus_wr = 0;
    bus_word = 0; rd_opt = 0; key_data = 0; okey_data = 0; bus_wdata = 0;
    ctl_wdata = 0; stat_wdata = 0; bus_hw_addr = 0; rd_hw_addr = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    // reset state
    check(busy, 0, "R4 reset busy");
    check(ctl_locked, 1, "R1 reset locked");
    check(opt_active, 64'hFFFF_FFFF_FFFF_FFFF, "R8 reset opt_active");
    rd(0, 8, 16'hFFFF, "R3 erased after por");

    // locked: option keys and control/program requests ignored
    okey_w(OKA); okey_w(OKB);
    check(opt_wen, 0, "R2 opt keys while locked");
    ctl_w(10'h001);
    bus_w(8, 0, 32'h0000_1111);
    repeat (3) @(negedge clk);
    check(busy, 0, "R9 locked request ignored");
    rd(0, 8, 16'hFFFF, "R9 locked no write");

    // wrong second key
    key_w(KA); key_w(32'h0BAD_0BAD);
    check(ctl_locked, 1, "R1 wrong key");
    key_w(KB);
    check(ctl_locked, 1, "R1 second key alone");
    key_w(KA); key_w(KB);
    check(ctl_locked, 0, "R1 unlocked");

    // half-word program with interrupt enable
    ctl_w(10'h021);
    bus_w(8, 0, 32'hAAAA_1234);
    wait_idle(n);
    check(n, PROG_CYC, "R4 program busy length");
    rd(0, 8, 16'h1234, "R3 half program");
    check(end_flag, 1, "R5 end set");
    check(irq, 1, "R5 irq");
    stat_w(2'b01);
    check(end_flag, 0, "R10 end cleared");
    check(irq, 0, "R5 irq low");

    // word program split across halves
    bus_w(33, 1, 32'hDEAD_BEEF);
    wait_idle(n);
    rd(0, 32, 16'hBEEF, "R3 word low half");
    rd(0, 33, 16'hDEAD, "R3 word high half");

    // request while busy ignored
    stat_w(2'b01);
    bus_w(40, 0, 32'h0000_7777);
    bus_w(41, 0, 32'h0000_6666);
    wait_idle(n);
    rd(0, 40, 16'h7777, "R3 first program");
    rd(0, 41, 16'hFFFF, "R9 busy request ignored");

    // overwrite non-erased with non-zero: error, no write
    stat_w(2'b01);
    bus_w(8, 0, 32'h0000_5555);
    wait_idle(n);
    @(negedge clk);
    check(prog_err, 1, "R6 error set");
    check(end_flag, 0, "R6 end not set");
    rd(0, 8, 16'h1234, "R6 memory unchanged");
    stat_w(2'b10);
    check(prog_err, 0, "R10 err cleared");

    // overwrite with zero allowed
    bus_w(8, 0, 32'h0000_0000);
    wait_idle(n);
    @(negedge clk);
    check(prog_err, 0, "R6 zero exempt");
    rd(0, 8, 16'h0000, "R6 zero written");

    // option program bit without option enable
    stat_w(2'b01);
    ctl_w(10'h002);
    bus_w(1, 0, 32'h0000_00A5);
    repeat (2) @(negedge clk);
    check(busy, 0, "R9 no enable ignored");

    // option area
    okey_w(OKA); okey_w(OKB);
    check(opt_wen, 1, "R2 opt enabled");
    ctl_w(10'h002);
    bus_w(1, 0, 32'h0000_33A5);
    wait_idle(n);
    rd(1, 1, 16'h5AA5, "R7 complement high byte");
    bus_w(2, 1, 32'h5533_4411);
    wait_idle(n);
    rd(1, 2, 16'hEE11, "R7 word even pair");
    rd(1, 3, 16'hCC33, "R7 word odd pair");
    check(opt_active, 64'hFFFF_FFFF_FFFF_FFFF, "R8 no effect before reset");
    stat_w(2'b01);
    bus_w(1, 0, 32'h0000_0012);
    wait_idle(n);
    @(negedge clk);
    check(prog_err, 1, "R7 option overwrite error");
    rd(1, 1, 16'h5AA5, "R7 pair kept");
    stat_w(2'b10);
    bus_w(1, 0, 32'h0000_0000);
    wait_idle(n);
    rd(1, 1, 16'hFF00, "R7 zero low byte");
    rd(1, 4, 16'hFFFF, "R12 untouched pair");

    // system reset: options take effect, arrays kept, path locked
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(opt_active, 64'hFFFF_FFFF_3311_00FF, "R8 reload after reset");
    check(ctl_locked, 1, "R1 locked after reset");
    rd(0, 8, 16'h0000, "R12 main kept over reset");

    // option erase
    key_w(KA); key_w(KB); okey_w(OKA); okey_w(OKB);
    ctl_w(10'h018);
    wait_idle(n);
    check(n, ERASE_CYC, "R4 erase busy length");
    rd(1, 2, 16'hFFFF, "R11 option erased");

    // page erase page 0 only
    ctl_w(10'h014);
    wait_idle(n);
    rd(0, 8, 16'hFFFF, "R11 page 0 erased");
    rd(0, 32, 16'hBEEF, "R11 page 2 kept");

    // lock again
    ctl_w(10'h040);
    check(ctl_locked, 1, "R1 relock");
    check(opt_wen, 0, "R2 drop on relock");
    bus_w(8, 0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    rd(0, 8, 16'hFFFF, "R9 relocked ignored");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule